// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects seven interrupt sources (two timers, a shift register and four edge-detecting control lines) into one flag register and one enable register, and drives a single active-low interrupt request. Each source raises its flag with a one-cycle set pulse. Other blocks can lower a flag with a one-cycle clear request. Software lowers flags by writing ones to the flag register. A set that arrives in the same cycle as any clear always wins, so no event is lost.

The flag register reads back with its top bit computed as a summary: it is 1 whenever some flag is set and its enable bit is also set. The request output is low exactly while that summary is 1. Software changes enable bits through one write port. The top bit of the written value selects whether the ones in the lower seven bits set or clear the matching enables. Bits written as zero are left as they were. Flag bit assignment, from bit 0 upward: second B control line, first B control line, shift register, second A control line, first A control line, timer 2, timer 1.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags and all enables are 0, the flag read value is 0x00, the enable read value is 0x80 and irq_n is 1.
- R2: A pulse on src_set[i] sets flag bit i at the next clock edge, whether or not enable bit i is set.
- R3: A flag-register write clears every flag whose written bit (6:0) is 1. Flags written as 0 keep their value, bit 7 of the written value has no effect, and a clear aimed at a flag that is already 0 leaves it 0.
- R4: When src_set[i] pulses in the same cycle as a clear of bit i (by register write or by src_clr[i]), flag i is 1 after the edge.
- R5: A pulse on src_clr[i] without a matching set clears flag bit i at the next clock edge.
- R6: Flag read bit 7 is 1 exactly when some bit i in 6:0 has both flag i and enable i set.
- R7: An enable write with data bit 7 = 1 sets each enable bit written as 1 and leaves the other enable bits unchanged.
- R8: An enable write with data bit 7 = 0 clears each enable bit written as 1 and leaves the other enable bits unchanged.
- R9: Enable read bit 7 is always 1, and bits 6:0 return the enables.
- R10: irq_n is 0 exactly while flag read bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_set | input | 7 | Per-source one-cycle flag set pulses |
| src_clr | input | 7 | Per-source one-cycle flag clear requests |
| wr_flag | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| wr_enable | input | 1 | Write strobe for the enable register |
| wdata | input | 8 | Register write data |
| flag_rdata | output | 8 | Flag register read value, bit 7 is the summary |
| enable_rdata | output | 8 | Enable register read value, bit 7 reads 1 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every piece of state can be seen at a read port one cycle after the edge that changes it. A wrong flag shows up in flag_rdata, and a wrong enable shows up in enable_rdata, right after the faulty edge. If the summary is wrong, irq_n and flag bit 7 disagree with the visible flags and enables in that same cycle. The directed scenarios therefore compare both read values and irq_n after every stimulated cycle. The priority cases put a set and a clear on the same bit in one cycle, because a clear-first bug can only be seen there.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned IRQ_SRC_N  = 7;
  // flag bit positions
  localparam int unsigned IRQ_B_CTL2 = 0;
  localparam int unsigned IRQ_B_CTL1 = 1;
  localparam int unsigned IRQ_SHIFT  = 2;
  localparam int unsigned IRQ_A_CTL2 = 3;
  localparam int unsigned IRQ_A_CTL1 = 4;
  localparam int unsigned IRQ_TMR2   = 5;
  localparam int unsigned IRQ_TMR1   = 6;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic               wr_flag,
  input  logic [NUM_SRC-1:0] wr_bits,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] clr_all;
  logic [NUM_SRC-1:0] flag_d;
  logic               flag_ce;

  always_comb begin
    clr_all = src_clr | (wr_flag ? wr_bits : '0);
    flag_ce = (|src_set) | (|clr_all);
  end

  // per-bit next state: a set beats any clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_comb begin
      flag_d[g] = src_set[g] | (flag_q[g] & ~clr_all[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_enable,
  input  logic               set_mode,
  input  logic [NUM_SRC-1:0] wr_bits,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] en_d;

  always_comb begin
    if (set_mode) en_d = en_q | wr_bits;
    else          en_d = en_q & ~wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= en_d;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic [NUM_SRC-1:0] flag_q,
  input  logic [NUM_SRC-1:0] en_q,
  output logic               any_active,
  output logic               irq_n
);
  logic [NUM_SRC-1:0] pend;

  always_comb begin
    pend       = flag_q & en_q;
    any_active = |pend;
    irq_n      = ~any_active;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQ_SRC_N,
  localparam int unsigned REG_W  = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic               wr_flag,
  input  logic               wr_enable,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   flag_rdata,
  output logic [REG_W-1:0]   enable_rdata,
  output logic               irq_n
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;
  logic               any_active;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .src_set (src_set),
    .src_clr (src_clr),
    .wr_flag (wr_flag),
    .wr_bits (wdata[NUM_SRC-1:0]),
    .flag_q  (flag_q)
  );

  irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_enables (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_enable (wr_enable),
    .set_mode  (wdata[REG_W-1]),
    .wr_bits   (wdata[NUM_SRC-1:0]),
    .en_q      (en_q)
  );

  irq_summary #(.NUM_SRC(NUM_SRC)) u_summary (
    .flag_q     (flag_q),
    .en_q       (en_q),
    .any_active (any_active),
    .irq_n      (irq_n)
  );

  assign flag_rdata   = {any_active, flag_q};
  assign enable_rdata = {1'b1, en_q};
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned NUM_SRC = 7,
  localparam int unsigned REG_W  = NUM_SRC + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_set,
  input logic [NUM_SRC-1:0] src_clr,
  input logic               wr_flag,
  input logic               wr_enable,
  input logic [REG_W-1:0]   wdata,
  input logic [REG_W-1:0]   flag_rdata,
  input logic [REG_W-1:0]   enable_rdata,
  input logic               irq_n
);
  // R4 / R2: every pulsed set is visible after the edge
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((flag_rdata[NUM_SRC-1:0] & $past(src_set)) == $past(src_set)));

  // R2: a flag only rises when its set pulse was present
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_rdata[NUM_SRC-1:0] & ~$past(flag_rdata[NUM_SRC-1:0]) & ~$past(src_set)) == '0));

  // R3 / R5: cleared bits without a concurrent set end up 0
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag || (src_clr != '0)) |=>
      ((flag_rdata[NUM_SRC-1:0] &
        ($past(src_clr) | ($past(wr_flag) ? $past(wdata[NUM_SRC-1:0]) : '0)) &
        ~$past(src_set)) == '0));

  // R7: set-mode enable write
  p_en_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && wdata[REG_W-1]) |=>
      ((enable_rdata[NUM_SRC-1:0] & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

  // R8: clear-mode enable write
  p_en_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && !wdata[REG_W-1]) |=>
      ((enable_rdata[NUM_SRC-1:0] & $past(wdata[NUM_SRC-1:0])) == '0));

  // R8 / R7: enables hold without a write
  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(enable_rdata));

  // R10: request pin tracks the summary bit
  p_irq_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !flag_rdata[REG_W-1]);

  // R6: summary against visible flags and enables
  p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdata[REG_W-1] == ((flag_rdata[NUM_SRC-1:0] & enable_rdata[NUM_SRC-1:0]) != '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_set      (src_set),
  .src_clr      (src_clr),
  .wr_flag      (wr_flag),
  .wr_enable    (wr_enable),
  .wdata        (wdata),
  .flag_rdata   (flag_rdata),
  .enable_rdata (enable_rdata),
  .irq_n        (irq_n)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] src_set;
  logic [6:0] src_clr;
  logic       wr_flag;
  logic       wr_enable;
  logic [7:0] wdata;
  logic [7:0] flag_rdata;
  logic [7:0] enable_rdata;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [6:0] exp_flag;
  logic [6:0] exp_en;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_set      (src_set),
    .src_clr      (src_clr),
    .wr_flag      (wr_flag),
    .wr_enable    (wr_enable),
    .wdata        (wdata),
    .flag_rdata   (flag_rdata),
    .enable_rdata (enable_rdata),
    .irq_n        (irq_n)
  );

  task automatic cmp(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // compare every output against the bench's expectation
  task automatic check_all(input string req);
    logic sum;
    sum = |(exp_flag & exp_en);
    cmp(req, "flag_rdata", flag_rdata, {sum, exp_flag});
    cmp(req, "enable_rdata", enable_rdata, {1'b1, exp_en});
    cmp(req, "irq_n", {7'd0, irq_n}, {7'd0, ~sum});
  endtask

  // apply one cycle of stimulus at a falling edge, return at the next one
  task automatic step(input logic [6:0] s, input logic [6:0] c,
                      input logic wf, input logic we, input logic [7:0] wd);
    logic [6:0] clr;
    src_set = s; src_clr = c; wr_flag = wf; wr_enable = we; wdata = wd;
    @(negedge clk);
    src_set = '0; src_clr = '0; wr_flag = 1'b0; wr_enable = 1'b0; wdata = '0;
    clr = c | (wf ? wd[6:0] : 7'd0);
    exp_flag = (exp_flag & ~clr) | s;
    if (we) exp_en = wd[7] ? (exp_en | wd[6:0]) : (exp_en & ~wd[6:0]);
  endtask

  task automatic t_reset;
    exp_flag = '0; exp_en = '0;
    check_all("R1");
    cmp("R9", "enable msb", {7'd0, enable_rdata[7]}, 8'd1);
  endtask

  task automatic t_set_without_enable;
    step(7'h55, '0, 1'b0, 1'b0, '0);   // R2
    check_all("R2");
    step(7'h40, '0, 1'b0, 1'b0, '0);   // timer 1 bit 6 again, already set
    check_all("R2");
  endtask

  task automatic t_enable_set;
    step('0, '0, 1'b0, 1'b1, 8'h81);   // R7 enable bit 0 -> summary
    check_all("R7");
    step('0, '0, 1'b0, 1'b1, 8'h82);   // R7 bit 1 added, bit 0 kept
    check_all("R6");
    cmp("R10", "irq_n low", {7'd0, irq_n}, 8'd0);
  endtask

  task automatic t_enable_clear;
    step('0, '0, 1'b0, 1'b1, 8'h01);   // R8 clear bit 0, bit 1 stays
    check_all("R8");
    step('0, '0, 1'b0, 1'b1, 8'h00);   // R8 zeros change nothing
    check_all("R8");
  endtask

  task automatic t_flag_clear;
    step('0, '0, 1'b1, 1'b0, 8'h85);   // R3 clear bits 0,2; bit 7 ignored
    check_all("R3");
    step('0, '0, 1'b1, 1'b0, 8'h02);   // R3 clears bit 1 (not set) -> stays 0
    check_all("R3");
    cmp("R10", "irq_n high", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_set_wins;
    step(7'h08, '0, 1'b1, 1'b0, 8'h08); // R4 bus clear vs set
    check_all("R4");
    step(7'h02, 7'h12, 1'b0, 1'b0, '0); // R4 src_clr vs set on bit 1, bit 4 cleared
    check_all("R4");
    cmp("R10", "irq_n low", {7'd0, irq_n}, 8'd0);
  endtask

  task automatic t_src_clear;
    step('0, 7'h02, 1'b0, 1'b0, '0);    // R5 clears the enabled flag
    check_all("R5");
    cmp("R6", "summary", {7'd0, flag_rdata[7]}, 8'd0);
    step('0, '0, 1'b1, 1'b0, 8'hFF);    // clear all
    check_all("R3");
    step('0, '0, 1'b0, 1'b1, 8'hFF);    // R9 all enables
    check_all("R9");
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_set = '0; src_clr = '0; wr_flag = 1'b0; wr_enable = 1'b0; wdata = '0;
    exp_flag = '0; exp_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_set_without_enable();
    t_enable_set();
    t_enable_clear();
    t_flag_clear();
    t_set_wins();
    t_src_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule